// File: doc/BRIEF.md
# Write-Combining Buffer Unit

This block is a single write-combining entry placed in front of main memory for weakly ordered, non-cacheable stores. The first combinable store that reaches an empty entry claims an address window. The window's size and its alignment are both equal to the entry's capacity. Later stores into that window are gathered into a line-wide data array. Each byte of the array carries its own valid bit, so stores may arrive in any order, and later bytes replace earlier ones.

The gathered line leaves as one wide transfer to the memory port. The transfer carries the line base address and a byte-enable mask, and the mask marks exactly the bytes that were written. Several things drain the entry: any of five ordering events on a sideband vector, a non-combinable access that names the active window, or a combinable store that falls outside it. While a drain is pending, new stores are held off with a ready signal. A non-combinable access is granted only when no gathered data shares its line.

Top module: `wcb_unit`

## Requirements
- R1: After reset the entry is empty: `mem_valid` is 0 and `wr_ready` is 1.
- R2: A store accepted by an empty entry sets the window base to its address with the low log2(LINE_BYTES) bits cleared, and `mem_addr` carries that base when the entry drains. Address bits below the word size are ignored, and bits [5:3] select the 8-byte word slot in the line.
- R3: Every accepted store whose line matches the window is merged, in any slot order. Byte b of `wr_data` (bits 8b+7:8b) lands in line byte slot*8+b when `wr_be[b]` is 1.
- R4: When several stores write the same byte, the byte holds the value of the store accepted last.
- R5: A combinable store outside the active window is held with `wr_ready` at 0. The old line drains first, and the held store then opens a new window.
- R6: `ncw_grant` is 0 while `ncw_valid` names the line of a non-empty entry. That condition starts a drain, and the grant rises only after the burst completes. A non-matching line is granted at once.
- R7: A pulse on any bit of `flush_evt` (store fence, serialize, I/O, locked op, interrupt/exception) drains a non-empty entry.
- R8: A `flush_evt` pulse on an empty entry issues no transfer.
- R9: While a transfer is pending, `wr_ready` is 0, and `mem_addr` and `mem_be` stay constant until `mem_ready` is 1.
- R10: Bytes never written since the window opened have `mem_be` at 0 and are driven as zero on `mem_data`.
- R11: The cycle after `mem_valid && mem_ready`, the entry is empty and the next store opens a new window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Combinable store request |
| wr_ready | output | 1 | Store accepted this cycle when high with wr_valid |
| wr_addr | input | ADDR_W | Store byte address |
| wr_data | input | 8*WORD_BYTES | Store data |
| wr_be | input | WORD_BYTES | Store byte enables |
| ncw_valid | input | 1 | Non-combinable access wants to proceed |
| ncw_addr | input | ADDR_W | Address of that access |
| ncw_grant | output | 1 | That access may proceed |
| flush_evt | input | NUM_EVT | Ordering events, any bit drains |
| mem_valid | output | 1 | Line transfer pending |
| mem_ready | input | 1 | Memory takes the transfer |
| mem_addr | output | ADDR_W | Line base address |
| mem_data | output | 8*LINE_BYTES | Line data, zero where unmasked |
| mem_be | output | LINE_BYTES | Per-byte enables |

## Verification
Most internal faults show up in the next burst, at the latest. A stale valid bit shows as a wrong `mem_be`. A wrong slot decode or merge order shows as a wrong byte in `mem_data`. A wrong window tag shows as a wrong `mem_addr`. Each of these appears in the one cycle the transfer is taken. Controller faults show up sooner. A missed trigger, or a ready or grant that opens early, changes `wr_ready`, `ncw_grant` or `mem_valid` within a cycle of the stimulus. The bench compares each captured burst, field by field, against a model of the line.

// File: rtl/wcb_pkg.sv
// Shared types for the write-combining unit.
package wcb_pkg;
    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_FILL  = 2'd1,
        ST_DRAIN = 2'd2
    } wcb_state_e;
endpackage

// File: rtl/wcb_window.sv
// Holds the tag of the active address window and compares incoming
// store and non-combinable addresses against it.
// Assumes: the tag is only meaningful while the entry is occupied.
module wcb_window #(
    parameter int TAG_W = 26
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [TAG_W-1:0] probe_tag,
    output logic [TAG_W-1:0] base_tag,
    output logic             wr_hit,
    output logic             probe_hit
);
    // Capture the window tag when a store opens the window.
    always_ff @(posedge clk) begin
        if (!rst_n)
            base_tag <= '0;
        else if (load)
            base_tag <= wr_tag;
    end

    assign wr_hit    = (wr_tag == base_tag);
    assign probe_hit = (probe_tag == base_tag);
endmodule

// File: rtl/wcb_store.sv
// Line-wide data array with one valid bit per byte. Merges a word-sized
// store into its slot and outputs the line with unwritten bytes zeroed.
// Assumes: clear and write are never requested in the same cycle.
module wcb_store #(
    parameter int LINE_BYTES = 64,
    parameter int WORD_BYTES = 8,
    localparam int NSLOT  = LINE_BYTES / WORD_BYTES,
    localparam int SLOT_W = $clog2(NSLOT)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic                    clr,
    input  logic [SLOT_W-1:0]       slot,
    input  logic [8*WORD_BYTES-1:0] data,
    input  logic [WORD_BYTES-1:0]   be,
    output logic [8*LINE_BYTES-1:0] line_data,
    output logic [LINE_BYTES-1:0]   line_be
);
    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        for (genvar b = 0; b < WORD_BYTES; b++) begin : g_byte
            localparam int IDX = s * WORD_BYTES + b;
            logic       vld;
            logic [7:0] byte_q;
            logic       hit;

            assign hit = wr_en && (slot == SLOT_W'(s)) && be[b];

            // Track whether this byte was written since the window opened.
            always_ff @(posedge clk) begin
                if (!rst_n || clr)
                    vld <= 1'b0;
                else if (hit)
                    vld <= 1'b1;
            end

            // Hold the most recent value written to this byte.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    byte_q <= '0;
                else if (hit)
                    byte_q <= data[8*b +: 8];
            end

            assign line_be[IDX]          = vld;
            assign line_data[8*IDX +: 8] = vld ? byte_q : 8'h00;
        end
    end
endmodule

// File: rtl/wcb_ctrl.sv
// Entry controller: empty / filling / draining. Decides when stores are
// accepted, when a drain starts and when the entry returns to empty.
// Assumes: hit inputs compare against the registered window tag.
module wcb_ctrl
    import wcb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_valid,
    input  logic wr_hit,
    input  logic evt_any,
    input  logic nc_valid,
    input  logic nc_hit,
    input  logic mem_ready,
    output logic wr_ready,
    output logic wr_take,
    output logic win_load,
    output logic drain_done,
    output logic mem_valid,
    output logic nc_grant
);
    wcb_state_e state, state_nx;
    logic       nc_conflict;
    logic       trigger;

    assign nc_conflict = nc_valid && nc_hit;
    assign trigger     = evt_any || nc_conflict || (wr_valid && !wr_hit);

    // Store acceptance depends on state and on pending drain triggers.
    always_comb begin
        unique case (state)
            ST_EMPTY: wr_ready = 1'b1;
            ST_FILL:  wr_ready = wr_hit && !evt_any && !nc_conflict;
            default:  wr_ready = 1'b0;
        endcase
    end

    assign wr_take    = wr_valid && wr_ready;
    assign win_load   = wr_take && (state == ST_EMPTY);
    assign mem_valid  = (state == ST_DRAIN);
    assign drain_done = mem_valid && mem_ready;
    assign nc_grant   = nc_valid && !((state != ST_EMPTY) && nc_hit);

    // Next-state selection.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_EMPTY: if (wr_take) state_nx = ST_FILL;
            ST_FILL:  if (trigger) state_nx = ST_DRAIN;
            default:  if (mem_ready) state_nx = ST_EMPTY;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_EMPTY;
        else
            state <= state_nx;
    end
endmodule

// File: rtl/wcb_unit.sv
// Single write-combining entry. Gathers combinable stores into one
// aligned line window and drains it as one masked line transfer.
// Assumes: stores are at most one word and do not cross a word boundary.
module wcb_unit #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64,
    parameter int WORD_BYTES = 8,
    parameter int NUM_EVT    = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_valid,
    output logic                    wr_ready,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [8*WORD_BYTES-1:0] wr_data,
    input  logic [WORD_BYTES-1:0]   wr_be,
    input  logic                    ncw_valid,
    input  logic [ADDR_W-1:0]       ncw_addr,
    output logic                    ncw_grant,
    input  logic [NUM_EVT-1:0]      flush_evt,
    output logic                    mem_valid,
    input  logic                    mem_ready,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [8*LINE_BYTES-1:0] mem_data,
    output logic [LINE_BYTES-1:0]   mem_be
);
    localparam int OFS_W = $clog2(LINE_BYTES);
    localparam int WB_W  = $clog2(WORD_BYTES);
    localparam int TAG_W = ADDR_W - OFS_W;

    logic             wr_hit, nc_hit, wr_take, win_load, drain_done;
    logic [TAG_W-1:0] base_tag;
    logic             unused_lo;

    assign unused_lo = ^{wr_addr[WB_W-1:0], ncw_addr[OFS_W-1:0]};

    wcb_window #(.TAG_W(TAG_W)) u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (win_load),
        .wr_tag    (wr_addr[ADDR_W-1:OFS_W]),
        .probe_tag (ncw_addr[ADDR_W-1:OFS_W]),
        .base_tag  (base_tag),
        .wr_hit    (wr_hit),
        .probe_hit (nc_hit)
    );

    wcb_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_valid   (wr_valid),
        .wr_hit     (wr_hit),
        .evt_any    (|flush_evt),
        .nc_valid   (ncw_valid),
        .nc_hit     (nc_hit),
        .mem_ready  (mem_ready),
        .wr_ready   (wr_ready),
        .wr_take    (wr_take),
        .win_load   (win_load),
        .drain_done (drain_done),
        .mem_valid  (mem_valid),
        .nc_grant   (ncw_grant)
    );

    wcb_store #(.LINE_BYTES(LINE_BYTES), .WORD_BYTES(WORD_BYTES)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_take),
        .clr       (drain_done),
        .slot      (wr_addr[OFS_W-1:WB_W]),
        .data      (wr_data),
        .be        (wr_be),
        .line_data (mem_data),
        .line_be   (mem_be)
    );

    assign mem_addr = {base_tag, {OFS_W{1'b0}}};
endmodule

// File: rtl/wcb_unit_chk.sv
// Protocol checker for wcb_unit, attached by bind.
module wcb_unit_chk #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64,
    localparam int OFS_W     = $clog2(LINE_BYTES)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wr_ready,
    input logic                  ncw_valid,
    input logic [ADDR_W-1:0]     ncw_addr,
    input logic                  ncw_grant,
    input logic                  mem_valid,
    input logic                  mem_ready,
    input logic [ADDR_W-1:0]     mem_addr,
    input logic [LINE_BYTES-1:0] mem_be
);
    logic unused_chk;
    assign unused_chk = ^ncw_addr[OFS_W-1:0];

    a_r9_ready_off_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> !wr_ready);

    a_r9_burst_held: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_be));

    a_r11_empty_after_take: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && mem_ready |=> !mem_valid);

    a_r2_base_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (mem_addr[OFS_W-1:0] == '0));

    a_r6_no_grant_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && ncw_valid && (ncw_addr[ADDR_W-1:OFS_W] == mem_addr[ADDR_W-1:OFS_W])
        |-> !ncw_grant);
endmodule

bind wcb_unit wcb_unit_chk #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_ready  (wr_ready),
    .ncw_valid (ncw_valid),
    .ncw_addr  (ncw_addr),
    .ncw_grant (ncw_grant),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .mem_be    (mem_be)
);

// File: tb/wcb_unit_tb.sv
`timescale 1ns/1ps
module wcb_unit_tb;
    localparam int AW = 32;
    localparam int LB = 64;
    localparam int WB = 8;
    localparam int NE = 5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_valid = 1'b0;
    logic            wr_ready;
    logic [AW-1:0]   wr_addr = '0;
    logic [63:0]     wr_data = '0;
    logic [7:0]      wr_be = '0;
    logic            ncw_valid = 1'b0;
    logic [AW-1:0]   ncw_addr = '0;
    logic            ncw_grant;
    logic [NE-1:0]   flush_evt = '0;
    logic            mem_valid;
    logic            mem_ready = 1'b1;
    logic [AW-1:0]   mem_addr;
    logic [511:0]    mem_data;
    logic [63:0]     mem_be;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    wcb_unit #(.ADDR_W(AW), .LINE_BYTES(LB), .WORD_BYTES(WB), .NUM_EVT(NE)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be),
        .ncw_valid(ncw_valid), .ncw_addr(ncw_addr), .ncw_grant(ncw_grant),
        .flush_evt(flush_evt), .mem_valid(mem_valid), .mem_ready(mem_ready),
        .mem_addr(mem_addr), .mem_data(mem_data), .mem_be(mem_be)
    );

    // Captured transfers and expected transfers.
    logic [AW-1:0] cap_addr [32];
    logic [511:0]  cap_data [32];
    logic [63:0]   cap_be   [32];
    int            cap_n = 0;
    logic [AW-1:0] exp_addr [32];
    logic [511:0]  exp_data [32];
    logic [63:0]   exp_be   [32];
    int            exp_n = 0;
    int            cmp_i = 0;

    always @(posedge clk) begin
        if (rst_n && mem_valid && mem_ready && cap_n < 32) begin
            cap_addr[cap_n] = mem_addr;
            cap_data[cap_n] = mem_data;
            cap_be[cap_n]   = mem_be;
            cap_n++;
        end
    end

    // Line model.
    bit            m_full = 1'b0;
    logic [AW-7:0] m_line = '0;
    logic [511:0]  m_data = '0;
    logic [63:0]   m_be = '0;

    task automatic check(input bit ok, input string tag, input logic [511:0] act, input logic [511:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic m_drain();
        if (m_full) begin
            exp_addr[exp_n] = {m_line, 6'b0};
            exp_data[exp_n] = m_data;
            exp_be[exp_n]   = m_be;
            exp_n++;
        end
        m_full = 1'b0;
        m_data = '0;
        m_be   = '0;
    endtask

    task automatic m_write(input logic [AW-1:0] a, input logic [63:0] d, input logic [7:0] be);
        int slot;
        if (m_full && a[AW-1:6] != m_line) m_drain();
        m_line = a[AW-1:6];
        m_full = 1'b1;
        slot = int'(a[5:3]);
        for (int b = 0; b < 8; b++) begin
            if (be[b]) begin
                m_data[8*(slot*8+b) +: 8] = d[8*b +: 8];
                m_be[slot*8+b] = 1'b1;
            end
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [63:0] d, input logic [7:0] be, output bit stalled);
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = a; wr_data = d; wr_be = be;
        stalled = 1'b0;
        #1;
        while (!wr_ready) begin
            stalled = 1'b1;
            @(negedge clk); #1;
        end
        @(posedge clk);
        #1 wr_valid = 1'b0;
        m_write(a, d, be);
    endtask

    task automatic pulse_evt(input logic [NE-1:0] v);
        @(negedge clk); flush_evt = v;
        @(negedge clk); flush_evt = '0;
        repeat (3) @(negedge clk);
        m_drain();
    endtask

    // Compare every new expected transfer against the captured one.
    task automatic cmp_bursts(input string tag);
        check(cap_n == exp_n, {tag, " count"}, 512'(cap_n), 512'(exp_n));
        while (cmp_i < exp_n) begin
            if (cmp_i < cap_n) begin
                check(cap_addr[cmp_i] == exp_addr[cmp_i], {tag, " R2 addr"}, 512'(cap_addr[cmp_i]), 512'(exp_addr[cmp_i]));
                check(cap_be[cmp_i] == exp_be[cmp_i], {tag, " R3/R10 be"}, 512'(cap_be[cmp_i]), 512'(exp_be[cmp_i]));
                check(cap_data[cmp_i] == exp_data[cmp_i], {tag, " R3/R4/R10 data"}, cap_data[cmp_i], exp_data[cmp_i]);
            end
            cmp_i++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        bit st;
        logic [AW-1:0] base;
        bit grant_seen;
        bit burst_seen;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: empty after reset.
        check(wr_ready == 1'b1, "R1 wr_ready", 512'(wr_ready), 512'(1));
        check(mem_valid == 1'b0, "R1 mem_valid", 512'(mem_valid), 512'(0));

        // Sweep: slot order, byte masks, overwrites, each event bit (R2 R3 R4 R7 R10).
        for (int p = 0; p < 8; p++) begin
            base = 32'h0001_0000 + 32'(p * 192);
            for (int i = 0; i < 8; i++) begin
                int slot;
                slot = (i * 3 + p) % 8;
                if ((p % 2 == 1) && ((slot + p) % 4 == 3)) continue;
                wr(base + 32'(slot * 8) + 32'(p % 8),
                   64'h0102_0304_0506_0708 * 64'(i + 1) + 64'(p) * 64'h1111,
                   8'hFF >> ((i + p) % 4), st);
            end
            wr(base + 32'(p * 8), 64'hDEAD_BEEF_0000_0000 + 64'(p), 8'hFF, st);
            wr(base + 32'(p * 8), 64'h5A5A_5A5A_5A5A_5A5A ^ 64'(p), 8'h3C, st);
            pulse_evt(NE'(1) << (p % 5));
            cmp_bursts("R7 sweep");
        end

        // R5: store outside the window is stalled, old line drains first.
        wr(32'h0002_0040, 64'h1111_2222_3333_4444, 8'hFF, st);
        wr(32'h0002_0058, 64'h5555_6666_7777_8888, 8'h0F, st);
        wr(32'h0002_0100, 64'h9999_AAAA_BBBB_CCCC, 8'hF0, st);
        check(st == 1'b1, "R5 stall", 512'(st), 512'(1));
        wr(32'h0002_0138, 64'hCAFE_F00D_1234_5678, 8'hFF, st);
        check(st == 1'b0, "R5 in new window", 512'(st), 512'(0));
        pulse_evt(5'b00100);
        cmp_bursts("R5 out-of-window");

        // R6: non-combinable probe.
        wr(32'h0003_0080, 64'h0BAD_0BAD_0BAD_0BAD, 8'h81, st);
        @(negedge clk);
        ncw_valid = 1'b1; ncw_addr = 32'h0003_0000;
        #1 check(ncw_grant == 1'b1, "R6 other line granted", 512'(ncw_grant), 512'(1));
        @(negedge clk);
        ncw_addr = 32'h0003_0090;
        #1 check(ncw_grant == 1'b0, "R6 match withheld", 512'(ncw_grant), 512'(0));
        m_drain();
        grant_seen = 1'b0;
        burst_seen = 1'b0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk); #1;
            if (ncw_grant) begin
                grant_seen = 1'b1;
                burst_seen = (cap_n == exp_n);
                break;
            end
        end
        check(grant_seen, "R6 grant after drain", 512'(grant_seen), 512'(1));
        check(burst_seen, "R6 drain before grant", 512'(burst_seen), 512'(1));
        ncw_valid = 1'b0;
        cmp_bursts("R6 probe");

        // R9 / R11: memory back-pressure.
        @(negedge clk); mem_ready = 1'b0;
        wr(32'h0004_0000, 64'h0F0F_0F0F_0F0F_0F0F, 8'h0F, st);
        @(negedge clk); flush_evt = 5'b00001;
        @(negedge clk); flush_evt = '0;
        m_drain();
        wr_valid = 1'b1; wr_addr = 32'h0004_0010; wr_data = 64'h7777_0000_7777_0000; wr_be = 8'hC3;
        repeat (4) @(negedge clk);
        #1;
        check(mem_valid == 1'b1, "R9 held valid", 512'(mem_valid), 512'(1));
        check(wr_ready == 1'b0, "R9 ready low", 512'(wr_ready), 512'(0));
        check(mem_addr == 32'h0004_0000, "R9 held addr", 512'(mem_addr), 512'(32'h0004_0000));
        check(cap_n == exp_n - 1, "R9 not taken", 512'(cap_n), 512'(exp_n - 1));
        mem_ready = 1'b1;
        @(negedge clk); #1;
        check(mem_valid == 1'b0, "R11 empty after take", 512'(mem_valid), 512'(0));
        check(wr_ready == 1'b1, "R11 ready after take", 512'(wr_ready), 512'(1));
        @(posedge clk);
        #1 wr_valid = 1'b0;
        m_write(32'h0004_0010, 64'h7777_0000_7777_0000, 8'hC3);
        pulse_evt(5'b10000);
        cmp_bursts("R9/R11 backpressure");

        // R8: event on an empty entry issues nothing.
        burst_seen = 1'b0;
        @(negedge clk); flush_evt = 5'b11111;
        @(negedge clk); flush_evt = '0;
        for (int k = 0; k < 4; k++) begin
            #1 if (mem_valid) burst_seen = 1'b1;
            @(negedge clk);
        end
        check(burst_seen == 1'b0, "R8 no transfer", 512'(burst_seen), 512'(0));
        cmp_bursts("R8 empty event");

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule